// File: doc/BRIEF.md
# CDMA Interference Regenerator

This block rebuilds, for one user, the chip-level picture of what that user adds to the received signal, so that a following cancellation stage can subtract it. It starts from the user's current real-valued symbol estimate. For each multipath in turn, the estimate is scaled by that path's complex channel gain. The weighted value is then multiplied by the user's spreading sign and complex scrambling chip on every chip position of the symbol. All SF chips of one path are presented side by side in one output word.

A symbol is launched with a one-cycle `start` while the block is idle. At that moment the symbol estimate, the per-path coefficients, the code chips, the spreading-factor select and the path count are captured. Each path then takes two cycles. The first cycle forms and registers the complex product of symbol and coefficient. The second cycle registers all chip lanes and raises `path_valid` together with the path index. A symbol with L paths therefore occupies 2×L cycles. Output chips are rounded back to signed 8-bit I/Q and saturated, and lanes beyond the selected spreading factor read zero.

Top module: `cdma_regen`

## Requirements
- R1: After a synchronous reset, `path_valid`, `path_last` and `busy` are low, and every chip lane of `chip_i` and `chip_q` is zero.
- R2: `start` is taken only while `busy` is low, and it captures all inputs in that cycle. A `start` or an input change while `busy` is high has no effect on the paths being produced.
- R3: If `start` is sampled at clock edge E0, the result for path p is registered at edge E0+2p+2, with `path_valid` high for exactly that one cycle. `path_valid` is low in the cycles between paths.
- R4: `path_idx` runs 0,1,…,L-1 over the paths of a symbol. `path_last` is high only with the final `path_valid`. `busy` is high from the edge after `start` through the cycle before the final path's edge, and it is low once the final path is shown.
- R5: The path count L is `num_paths`, except that 0 is treated as 1 and any value above L_MAX (6) is treated as L_MAX. Path p uses coefficient bits [8p+7:8p] of `coef_re` and `coef_im`.
- R6: With symbol s and coefficient c = cr + j·ci (both signed 8-bit), the products are pr = s·cr and pi = s·ci. Lane n uses spread bit w, scrambling bits a and b (bit value 1 means −1, 0 means +1). Before scaling, lane n's I value is w·(a·pr − b·pi) and its Q value is w·(a·pi + b·pr). Lane n sits at bits [8n+7:8n].
- R7: Each lane value v is scaled as (v + 64) >> 7, an arithmetic shift, which rounds halves toward plus infinity.
- R8: Scaled values above 127 are output as 127, and values below −128 are output as −128.
- R9: `sf_log2` = k selects SF = 2^k for k = 0..4; larger k selects 16. Lanes n ≥ SF output zero on both I and Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one symbol (taken only when idle) |
| sym_est | input | 8 | Real symbol estimate, signed |
| coef_re | input | 48 | Real parts of the per-path coefficients, 8 bits per path |
| coef_im | input | 48 | Imaginary parts of the per-path coefficients, 8 bits per path |
| spread_code | input | 16 | Spreading sign per chip (1 = −1) |
| scr_i | input | 16 | Scrambling chip real sign per chip (1 = −1) |
| scr_q | input | 16 | Scrambling chip imaginary sign per chip (1 = −1) |
| sf_log2 | input | 3 | log2 of the spreading factor |
| num_paths | input | 3 | Number of multipaths |
| busy | output | 1 | A symbol is in progress |
| path_valid | output | 1 | Chip lanes hold one path's image |
| path_idx | output | 3 | Index of the path shown |
| path_last | output | 1 | The path shown is the symbol's last |
| chip_i | output | 128 | In-phase chip lanes, signed 8 bits each |
| chip_q | output | 128 | Quadrature chip lanes, signed 8 bits each |

## Verification
The bench drives full-scale operands toward both rails. A design that wrapped instead of clamping would emit chips of the wrong sign. It also sets products that sit exactly on a rounding half, where truncation or round-to-zero would be off by one. Short spreading factors are checked for zeroed upper lanes, since stale lanes would make the cancellation stage subtract phantom chips. Path counts of 0 and above the maximum, along with a second `start` plus fresh inputs while a symbol is in flight, catch a controller that loops wrongly or recaptures mid-symbol.

// File: rtl/cdma_regen_pkg.sv
package cdma_regen_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_SPRD = 2'd2
  } regen_state_t;
endpackage

// File: rtl/cdma_regen_ctrl.sv
module cdma_regen_ctrl
  import cdma_regen_pkg::*;
#(
  parameter int L_MAX = 6,
  parameter int NP_W  = 3,
  parameter int PI_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [NP_W-1:0] num_paths,
  output logic            capture,
  output logic            mul_en,
  output logic            spr_en,
  output logic [PI_W-1:0] cur_path,
  output logic            busy,
  output logic            path_valid,
  output logic [PI_W-1:0] path_idx,
  output logic            path_last
);
  regen_state_t    state_q;
  logic [PI_W-1:0] last_idx_q;
  logic [PI_W-1:0] last_idx_d;

  // clamp requested path count to 1..L_MAX, keep as last index
  always_comb begin
    if (num_paths == '0)
      last_idx_d = '0;
    else if (int'(num_paths) > L_MAX)
      last_idx_d = PI_W'(L_MAX - 1);
    else
      last_idx_d = PI_W'(num_paths - 1'b1);
  end

  assign capture = (state_q == ST_IDLE) && start;
  assign mul_en  = (state_q == ST_MUL);
  assign spr_en  = (state_q == ST_SPRD);
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      cur_path   <= '0;
      last_idx_q <= '0;
      path_valid <= 1'b0;
      path_idx   <= '0;
      path_last  <= 1'b0;
    end else begin
      path_valid <= 1'b0;
      path_last  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            last_idx_q <= last_idx_d;
            cur_path   <= '0;
            state_q    <= ST_MUL;
          end
        end
        ST_MUL: state_q <= ST_SPRD;
        ST_SPRD: begin
          path_valid <= 1'b1;
          path_idx   <= cur_path;
          if (cur_path == last_idx_q) begin
            path_last <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            cur_path <= cur_path + 1'b1;
            state_q  <= ST_MUL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cdma_regen_weight.sv
module cdma_regen_weight #(
  parameter int L_MAX = 6,
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int PI_W  = 3,
  parameter int PW    = DW + CW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  capture,
  input  logic                  mul_en,
  input  logic [PI_W-1:0]       cur_path,
  input  logic [DW-1:0]         sym_est,
  input  logic [L_MAX*CW-1:0]   coef_re,
  input  logic [L_MAX*CW-1:0]   coef_im,
  output logic signed [PW-1:0]  prod_re,
  output logic signed [PW-1:0]  prod_im
);
  logic signed [DW-1:0] sym_q;
  logic signed [CW-1:0] cre_q [L_MAX];
  logic signed [CW-1:0] cim_q [L_MAX];

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_q   <= '0;
      prod_re <= '0;
      prod_im <= '0;
      for (int l = 0; l < L_MAX; l++) begin
        cre_q[l] <= '0;
        cim_q[l] <= '0;
      end
    end else begin
      if (capture) begin
        sym_q <= sym_est;
        for (int l = 0; l < L_MAX; l++) begin
          cre_q[l] <= coef_re[l*CW +: CW];
          cim_q[l] <= coef_im[l*CW +: CW];
        end
      end
      // first cycle of a path: weight the real estimate by the gain
      if (mul_en) begin
        prod_re <= PW'(sym_q) * PW'(cre_q[cur_path]);
        prod_im <= PW'(sym_q) * PW'(cim_q[cur_path]);
      end
    end
  end
endmodule

// File: rtl/cdma_regen_lane.sv
module cdma_regen_lane #(
  parameter int DW   = 8,
  parameter int PW   = 16,
  parameter int FRAC = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 lane_on,
  input  logic                 spr,
  input  logic                 sci,
  input  logic                 scq,
  input  logic signed [PW-1:0] prod_re,
  input  logic signed [PW-1:0] prod_im,
  output logic signed [DW-1:0] chip_i,
  output logic signed [DW-1:0] chip_q
);
  localparam int SW = PW + 2;
  localparam logic signed [SW-1:0] HI = SW'((1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] LO = SW'(-(1 <<< (DW-1)));
  localparam logic signed [SW-1:0] HALF = SW'(1 <<< (FRAC-1));

  logic signed [SW-1:0] pr, pi, ar, ai, br, bi, re_s, im_s, re_w, im_w;

  always_comb begin
    pr   = SW'(prod_re);
    pi   = SW'(prod_im);
    ar   = sci ? -pr : pr;
    ai   = sci ? -pi : pi;
    br   = scq ? -pr : pr;
    bi   = scq ? -pi : pi;
    re_s = ar - bi;
    im_s = ai + br;
    re_w = spr ? -re_s : re_s;
    im_w = spr ? -im_s : im_s;
  end

  function automatic logic signed [DW-1:0] rnd_sat(input logic signed [SW-1:0] x);
    logic signed [SW-1:0] r;
    r = (x + HALF) >>> FRAC;
    if (r > HI)      rnd_sat = HI[DW-1:0];
    else if (r < LO) rnd_sat = LO[DW-1:0];
    else             rnd_sat = r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_i <= '0;
      chip_q <= '0;
    end else if (load) begin
      chip_i <= lane_on ? rnd_sat(re_w) : '0;
      chip_q <= lane_on ? rnd_sat(im_w) : '0;
    end
  end
endmodule

// File: rtl/cdma_regen.sv
module cdma_regen #(
  parameter int SF_MAX = 16,
  parameter int L_MAX  = 6,
  parameter int DW     = 8,
  parameter int CW     = 8,
  // derived widths, keep at their defaults
  parameter int SFL_W  = $clog2($clog2(SF_MAX) + 1),
  parameter int NP_W   = $clog2(L_MAX + 1),
  parameter int PI_W   = (L_MAX > 1) ? $clog2(L_MAX) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DW-1:0]        sym_est,
  input  logic [L_MAX*CW-1:0]  coef_re,
  input  logic [L_MAX*CW-1:0]  coef_im,
  input  logic [SF_MAX-1:0]    spread_code,
  input  logic [SF_MAX-1:0]    scr_i,
  input  logic [SF_MAX-1:0]    scr_q,
  input  logic [SFL_W-1:0]     sf_log2,
  input  logic [NP_W-1:0]      num_paths,
  output logic                 busy,
  output logic                 path_valid,
  output logic [PI_W-1:0]      path_idx,
  output logic                 path_last,
  output logic [SF_MAX*DW-1:0] chip_i,
  output logic [SF_MAX*DW-1:0] chip_q
);
  localparam int PW         = DW + CW;
  localparam int FRAC       = CW - 1;
  localparam int SF_LOG_MAX = $clog2(SF_MAX);

  logic            capture, mul_en, spr_en;
  logic [PI_W-1:0] cur_path;
  logic signed [PW-1:0] prod_re, prod_im;
  logic [SF_MAX-1:0] spr_q, sci_q, scq_q, lane_on_q;

  function automatic logic [SF_MAX-1:0] mask_for(input logic [SFL_W-1:0] k);
    int n;
    n = (int'(k) > SF_LOG_MAX) ? SF_MAX : (1 << k);
    for (int i = 0; i < SF_MAX; i++) mask_for[i] = (i < n);
  endfunction

  cdma_regen_ctrl #(.L_MAX(L_MAX), .NP_W(NP_W), .PI_W(PI_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .num_paths(num_paths),
    .capture(capture), .mul_en(mul_en), .spr_en(spr_en), .cur_path(cur_path),
    .busy(busy), .path_valid(path_valid), .path_idx(path_idx), .path_last(path_last)
  );

  cdma_regen_weight #(.L_MAX(L_MAX), .DW(DW), .CW(CW), .PI_W(PI_W), .PW(PW)) u_weight (
    .clk(clk), .rst(rst), .capture(capture), .mul_en(mul_en), .cur_path(cur_path),
    .sym_est(sym_est), .coef_re(coef_re), .coef_im(coef_im),
    .prod_re(prod_re), .prod_im(prod_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      spr_q     <= '0;
      sci_q     <= '0;
      scq_q     <= '0;
      lane_on_q <= '0;
    end else if (capture) begin
      spr_q     <= spread_code;
      sci_q     <= scr_i;
      scq_q     <= scr_q;
      lane_on_q <= mask_for(sf_log2);
    end
  end

  for (genvar n = 0; n < SF_MAX; n++) begin : g_lane
    cdma_regen_lane #(.DW(DW), .PW(PW), .FRAC(FRAC)) u_lane (
      .clk(clk), .rst(rst), .load(spr_en), .lane_on(lane_on_q[n]),
      .spr(spr_q[n]), .sci(sci_q[n]), .scq(scq_q[n]),
      .prod_re(prod_re), .prod_im(prod_im),
      .chip_i(chip_i[n*DW +: DW]), .chip_q(chip_q[n*DW +: DW])
    );
  end
endmodule

// File: rtl/cdma_regen_chk.sv
module cdma_regen_chk #(
  parameter int L_MAX = 6,
  parameter int PI_W  = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            path_valid,
  input logic [PI_W-1:0] path_idx,
  input logic            path_last
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!path_valid && !busy && !path_last));

  a_r2_start_taken: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r3_first_path: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |-> ##3 (path_valid && path_idx == '0));

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    path_valid |=> !path_valid);

  a_r4_next_index: assert property (@(posedge clk) disable iff (rst)
    (path_valid && !path_last) |-> ##2 (path_valid && path_idx == PI_W'($past(path_idx, 2) + 1'b1)));

  a_r4_last_idle: assert property (@(posedge clk) disable iff (rst)
    path_last |-> (path_valid && !busy));

  a_r5_index_range: assert property (@(posedge clk) disable iff (rst)
    path_valid |-> (int'(path_idx) < L_MAX));
endmodule

bind cdma_regen cdma_regen_chk #(.L_MAX(L_MAX), .PI_W(PI_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy),
  .path_valid(path_valid), .path_idx(path_idx), .path_last(path_last)
);

// File: tb/tb_cdma_regen.sv
`timescale 1ns/1ps
module tb_cdma_regen;
  localparam int SFM = 16;
  localparam int LM  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [7:0]  sym = '0;
  logic [47:0] cre = '0, cim = '0;
  logic [15:0] spr = '0, sci = '0, scq = '0;
  logic [2:0]  sfk = 3'd4, np = 3'd6;
  logic busy, path_valid, path_last;
  logic [2:0] path_idx;
  logic [127:0] chip_i, chip_q;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cdma_regen dut (
    .clk(clk), .rst(rst), .start(start), .sym_est(sym),
    .coef_re(cre), .coef_im(cim), .spread_code(spr), .scr_i(sci), .scr_q(scq),
    .sf_log2(sfk), .num_paths(np), .busy(busy), .path_valid(path_valid),
    .path_idx(path_idx), .path_last(path_last), .chip_i(chip_i), .chip_q(chip_q)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_chip(input int s, input int c_re, input int c_im,
                                  input bit w, input bit an, input bit bn, input bit imag);
    int pr, pi, a, b, v, r;
    pr = s * c_re;
    pi = s * c_im;
    a = an ? -1 : 1;
    b = bn ? -1 : 1;
    v = imag ? (a*pi + b*pr) : (a*pr - b*pi);
    if (w) v = -v;
    r = (v + 64) >>> 7;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic run_sym(input string tag, input bit inject);
    logic [7:0] s_sym; logic [47:0] s_cre, s_cim; logic [15:0] s_spr, s_sci, s_scq;
    int leff, sfe, p;
    bit tbad, cbad;
    int act_v, exp_v, bad_lane;
    s_sym = sym; s_cre = cre; s_cim = cim; s_spr = spr; s_sci = sci; s_scq = scq;
    leff = (np == 0) ? 1 : ((int'(np) > LM) ? LM : int'(np));
    sfe  = (sfk > 4) ? SFM : (1 << sfk);
    tbad = 0;
    p = 0;
    @(negedge clk);
    start = 1'b1;
    for (int c = 1; c <= 2*leff + 3; c++) begin
      bit ev;
      @(negedge clk);
      if (c == 1) begin
        start = inject;
        if (inject) begin
          sym = ~sym; cre = ~cre; cim = ~cim; spr = ~spr; sfk = 3'd1; np = 3'd1;
        end
      end
      if (c == 3) start = 1'b0;
      ev = (c >= 3) && (c <= 2*leff + 1) && (c % 2 == 1);
      if (path_valid !== ev) tbad = 1;
      if (busy !== (c <= 2*leff)) tbad = 1;
      if (ev) begin
        if (path_idx !== 3'(p) || path_last !== (p == leff - 1)) tbad = 1;
        cbad = 0; act_v = 0; exp_v = 0; bad_lane = 0;
        for (int n = 0; n < SFM; n++) begin
          for (int q = 0; q < 2; q++) begin
            int e, a;
            e = (n >= sfe) ? 0 :
                exp_chip(int'($signed(s_sym)), int'($signed(s_cre[p*8 +: 8])),
                         int'($signed(s_cim[p*8 +: 8])), s_spr[n], s_sci[n], s_scq[n], q[0]);
            a = q ? int'($signed(chip_q[n*8 +: 8])) : int'($signed(chip_i[n*8 +: 8]));
            if (a != e && !cbad) begin
              cbad = 1; act_v = a; exp_v = e; bad_lane = n;
            end
          end
        end
        chk(!cbad, tag, $sformatf("path %0d lane %0d chip", p, bad_lane), act_v, exp_v);
        p++;
      end
    end
    chk(!tbad && p == leff, "R3 R4", {tag, " path timing/index/busy"}, p, leff);
  endtask

  task automatic rand_inputs();
    sym = 8'($urandom); cre = {16'($urandom), 32'($urandom)}; cim = {16'($urandom), 32'($urandom)};
    spr = 16'($urandom); sci = 16'($urandom); scq = 16'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(path_valid === 1'b0 && busy === 1'b0 && path_last === 1'b0, "R1", "flags after reset",
        {path_valid, busy, path_last}, 0);
    chk(chip_i === '0 && chip_q === '0, "R1", "chips after reset", 64'(chip_i[63:0]), 0);

    // R8: positive rail
    sym = 8'sd127; cre = {6{8'sd127}}; cim = {6{8'sd127}};
    spr = '0; sci = '0; scq = '0; sfk = 3'd4; np = 3'd6;
    run_sym("R8", 0);
    // R8: negative rail
    sym = 8'h80; cre = {6{8'h80}}; cim = {6{8'h80}}; sci = '1;
    run_sym("R8", 0);
    // R7: rounding at halves and just below
    sym = 8'd1; cre = {8'sd127, 8'sd0, -8'sd65, -8'sd64, 8'sd63, 8'sd64}; cim = {8'sd0, 8'sd64, 8'sd0, 8'sd0, 8'sd0, 8'sd0};
    spr = 16'hA5A5; sci = 16'h0FF0; scq = 16'h3C3C;
    run_sym("R7", 0);
    // R9: each spreading factor plus an out-of-range select
    for (int k = 0; k < 8; k++) begin
      rand_inputs(); sfk = 3'(k); np = 3'd2;
      run_sym("R9", 0);
    end
    // R5: path-count clamping
    rand_inputs(); sfk = 3'd4; np = 3'd0;
    run_sym("R5", 0);
    rand_inputs(); np = 3'd7;
    run_sym("R5", 0);
    // R2: start and new inputs while busy
    rand_inputs(); sfk = 3'd3; np = 3'd4;
    run_sym("R2", 1);
    // R6: random symbols
    for (int i = 0; i < 40; i++) begin
      rand_inputs(); sfk = 3'($urandom_range(0, 7)); np = 3'($urandom_range(0, 7));
      run_sym("R6", 0);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule